// File: doc/BRIEF.md
# Dual-Channel Transmit Queue Controller

This block sits between a host register bus and the byte-wide transmit side of an Ethernet MAC. It holds two independent transmit byte queues. Software picks a channel through a select register and pushes 32-bit words through one shared data register. It programs a frame length for each channel and then writes a start bit for that channel. A started channel sends the bytes it holds, one per accepted cycle, on a byte stream that marks the first and last byte of each frame and shows which channel the byte came from.

The block also holds the interrupt status and mask for three events: completion on channel 0, completion on channel 1, and a receive event reported by the receive path. The interrupt line is the OR of the status bits that are enabled. A bit in the control register resets the block's whole state. That reset is also passed on as a flush pulse to the receive path.

Only one frame is on the stream at a time. A channel that is started while the other channel is sending waits its turn and goes next.

Top module: `dual_txq`

## Requirements
- R1: A write to the channel-select register (address 1) stores the value when it is below 2, and stores 0 for any value of 2 or more. It reads back on the same address.
- R2: A write to the data register (address 2) appends the 32-bit word to the selected channel's queue as four bytes. The least-significant byte goes first. The bytes leave on `tx_data` in the order they were queued.
- R3: A data write that finds fewer than 4 free bytes in the selected queue (FIFO_BYTES per channel) is dropped, and the queued data is left unchanged.
- R4: A write to a length register (address 3 for channel 0, address 4 for channel 1) stores the value clamped to FIFO_BYTES. It reads back on the same address.
- R5: A write with bit 0 set to a start register (address 5 for channel 0, address 6 for channel 1) starts that channel only while control bit 0 (transmit enable) is 1. Otherwise it has no effect, and the queued data stays.
- R6: A start sends min(programmed length, bytes queued) bytes. When that number is zero, nothing is sent and no status bit is set.
- R7: After the last byte of a frame is accepted, that channel's queue and length are cleared, and the channel's status bit is set (bit 0 for channel 0, bit 1 for channel 1).
- R8: The stream moves one byte on each cycle in which `tx_valid` and `tx_ready` are both 1. While `tx_ready` is 0, the byte and its markers hold. `tx_sof` marks the first byte of a frame and `tx_eof` marks the last.
- R9: `irq` is 1 exactly when some status bit (address 8) is set together with its mask bit (address 7). A write to address 8 clears the status bits written as 1 and leaves the others unchanged.
- R10: A status bit that is set and cleared by a write-one in the same cycle ends up set.
- R11: A control write (address 0) with bit 2 set clears both queues, both lengths, any frame in flight, status, mask and channel select, and pulses `rx_flush` in the write cycle. The other written bits are stored, and bit 2 reads back as 0.
- R12: A start on a channel that is already busy is ignored. A start on a channel while the other channel is sending is held, and that frame is sent after the current one.
- R13: A pulse on `rx_done` sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| rx_done | input | 1 | Receive event pulse |
| rx_flush | output | 1 | Receive-path flush pulse from a control reset |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| tx_chan | output | 1 | Channel that sourced the byte |
| irq | output | 1 | Interrupt request |

## Verification
Frame completion sets a status bit, and a write-one to the status register clears it. These two can land on the same clock edge. The receive pulse can also coincide with a clear of its own bit. The bench provokes both cases by stalling a one-byte frame with its last byte presented and `tx_ready` low. In one cycle it then raises `tx_ready`, writes the clear mask for bits 0 and 2, and pulses `rx_done`. Afterwards both bits are expected to read as set. A second collision lines up a start on one channel with the other channel's stream in flight. It is judged by the order and the channel tags of the bytes that come out.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int NUM_CH = 2;
  localparam int IRQ_W  = 3;
  localparam int IRQ_RX = 2;

  localparam int CTRL_TXEN = 0;
  localparam int CTRL_RST  = 2;

  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_CHSEL = 4'd1,
    A_DATA  = 4'd2,
    A_LEN0  = 4'd3,
    A_LEN1  = 4'd4,
    A_GO0   = 4'd5,
    A_GO1   = 4'd6,
    A_IMASK = 4'd7,
    A_ISTAT = 4'd8
  } txq_addr_e;

endpackage

// File: rtl/txq_rst_sync.sv
module txq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/txq_chan.sv
module txq_chan #(
  parameter int FIFO_BYTES = 2048
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              push,
  input  logic [31:0]                       push_word,
  input  logic                              len_we,
  input  logic [$clog2(FIFO_BYTES):0]       len_val,
  input  logic                              go,
  input  logic                              tx_en,
  input  logic                              pop,
  output logic                              pend,
  output logic [7:0]                        byte_o,
  output logic                              first,
  output logic                              last,
  output logic                              done,
  output logic [$clog2(FIFO_BYTES):0]       len_q
);
  localparam int WORDS = FIFO_BYTES / 4;
  localparam int WAW   = $clog2(WORDS);
  localparam int CW    = WAW + 1;
  localparam int LW    = $clog2(FIFO_BYTES) + 1;
  localparam int BW    = $clog2(FIFO_BYTES);
  localparam logic [CW-1:0] WORDS_C = CW'(WORDS);

  logic [31:0]   mem [WORDS];
  logic [CW-1:0] wcnt, wcnt_d;
  logic [LW-1:0] rptr, rptr_d;
  logic [LW-1:0] rem, rem_d;
  logic [LW-1:0] len_d;
  logic          pend_d;
  logic [LW-1:0] queued, eff;
  logic          start, push_ok, en;
  logic [WAW-1:0] waddr;

  assign queued  = {wcnt, 2'b00};
  assign eff     = (len_q < queued) ? len_q : queued;
  assign start   = go && tx_en && !pend && (eff != '0);
  assign last    = pend && (rem == LW'(1));
  assign first   = (rptr == '0);
  assign done    = pop && last;
  assign push_ok = push && (done || (wcnt < WORDS_C));
  assign waddr   = done ? '0 : wcnt[WAW-1:0];
  assign en      = clr | len_we | push_ok | start | pop;

  always_comb begin
    pend_d = pend;
    rem_d  = rem;
    rptr_d = rptr;
    wcnt_d = wcnt;
    len_d  = len_q;
    if (len_we)  len_d  = len_val;
    if (push_ok) wcnt_d = wcnt + CW'(1);
    if (start) begin
      pend_d = 1'b1;
      rem_d  = eff;
    end
    if (pop) begin
      rptr_d = rptr + LW'(1);
      rem_d  = rem - LW'(1);
    end
    if (done) begin
      pend_d = 1'b0;
      rptr_d = '0;
      len_d  = len_we ? len_val : '0;
      wcnt_d = push_ok ? CW'(1) : '0;
    end
    if (clr) begin
      pend_d = 1'b0;
      rem_d  = '0;
      rptr_d = '0;
      wcnt_d = '0;
      len_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      rem   <= '0;
      rptr  <= '0;
      wcnt  <= '0;
      len_q <= '0;
    end else if (en) begin
      pend  <= pend_d;
      rem   <= rem_d;
      rptr  <= rptr_d;
      wcnt  <= wcnt_d;
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[waddr] <= push_word;
  end

  assign byte_o = mem[rptr[BW-1:2]][8*rptr[1:0] +: 8];
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  input  logic         mask_we,
  input  logic [W-1:0] mask_val,
  input  logic         w1c_we,
  input  logic [W-1:0] w1c_val,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] stat_d, mask_d, clr_bits;

  assign clr_bits = w1c_we ? w1c_val : '0;

  always_comb begin
    stat_d = (stat & ~clr_bits) | set;
    mask_d = mask_we ? mask_val : mask;
    if (clr) begin
      stat_d = '0;
      mask_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= stat_d;
      mask <= mask_d;
    end
  end

  assign irq = |(stat & mask);
endmodule

// File: rtl/dual_txq.sv
module dual_txq #(
  parameter int FIFO_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        rx_done,
  output logic        rx_flush,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_sof,
  output logic        tx_eof,
  output logic        tx_chan,
  output logic        irq
);
  import txq_pkg::*;

  localparam int LW = $clog2(FIFO_BYTES) + 1;
  localparam logic [31:0]   FB32 = 32'(FIFO_BYTES);
  localparam logic [LW-1:0] FBL  = LW'(FIFO_BYTES);

  logic rst_sn;
  txq_rst_sync u_rs (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  logic          soft_clr;
  logic [31:0]   ctrl_q, ctrl_d;
  logic          chsel_q, chsel_d;
  logic          act_vld, act_vld_d;
  logic          act_ch, act_ch_d;
  logic [LW-1:0] len_clamped;
  logic [IRQ_W-1:0] istat, imask, iset;

  logic [NUM_CH-1:0] pend, first, last, done, pop, go, push, len_we;
  logic [7:0]        chbyte [NUM_CH];
  logic [LW-1:0]     chlen  [NUM_CH];

  assign soft_clr    = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_RST];
  assign rx_flush    = soft_clr;
  assign len_clamped = (wr_data > FB32) ? FBL : wr_data[LW-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [3:0] A_LEN_I = 4'(int'(A_LEN0) + i);
    localparam logic [3:0] A_GO_I  = 4'(int'(A_GO0) + i);

    assign go[i]     = wr_en && (wr_addr == A_GO_I) && wr_data[0];
    assign len_we[i] = wr_en && (wr_addr == A_LEN_I);
    assign push[i]   = wr_en && (wr_addr == A_DATA) && (chsel_q == 1'(i));
    assign pop[i]    = act_vld && (act_ch == 1'(i)) && tx_ready;

    txq_chan #(.FIFO_BYTES(FIFO_BYTES)) u_chan (
      .clk(clk), .rst_n(rst_sn), .clr(soft_clr),
      .push(push[i]), .push_word(wr_data),
      .len_we(len_we[i]), .len_val(len_clamped),
      .go(go[i]), .tx_en(ctrl_q[CTRL_TXEN]), .pop(pop[i]),
      .pend(pend[i]), .byte_o(chbyte[i]), .first(first[i]),
      .last(last[i]), .done(done[i]), .len_q(chlen[i])
    );
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    chsel_d = chsel_q;
    if (wr_en && (wr_addr == A_CTRL)) begin
      ctrl_d = wr_data;
      ctrl_d[CTRL_RST] = 1'b0;
    end
    if (wr_en && (wr_addr == A_CHSEL))
      chsel_d = (wr_data < 32'(NUM_CH)) ? wr_data[0] : 1'b0;
    if (soft_clr) chsel_d = 1'b0;
  end

  always_comb begin
    act_vld_d = act_vld;
    act_ch_d  = act_ch;
    if (act_vld) begin
      if (tx_ready && last[act_ch]) act_vld_d = 1'b0;
    end else if (|pend) begin
      act_vld_d = 1'b1;
      act_ch_d  = pend[0] ? 1'b0 : 1'b1;
    end
    if (soft_clr) act_vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q  <= '0;
      chsel_q <= 1'b0;
      act_vld <= 1'b0;
      act_ch  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      chsel_q <= chsel_d;
      act_vld <= act_vld_d;
      act_ch  <= act_ch_d;
    end
  end

  assign iset = {rx_done, done[1], done[0]};

  txq_irq #(.W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_sn), .clr(soft_clr), .set(iset),
    .mask_we(wr_en && (wr_addr == A_IMASK)), .mask_val(wr_data[IRQ_W-1:0]),
    .w1c_we(wr_en && (wr_addr == A_ISTAT)), .w1c_val(wr_data[IRQ_W-1:0]),
    .stat(istat), .mask(imask), .irq(irq)
  );

  assign tx_valid = act_vld;
  assign tx_chan  = act_ch;
  assign tx_data  = act_vld ? chbyte[act_ch] : 8'h00;
  assign tx_sof   = act_vld && first[act_ch];
  assign tx_eof   = act_vld && last[act_ch];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_CHSEL: rd_data = {31'b0, chsel_q};
      A_LEN0:  rd_data = {{(32-LW){1'b0}}, chlen[0]};
      A_LEN1:  rd_data = {{(32-LW){1'b0}}, chlen[1]};
      A_IMASK: rd_data = {{(32-IRQ_W){1'b0}}, imask};
      A_ISTAT: rd_data = {{(32-IRQ_W){1'b0}}, istat};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dual_txq_chk.sv
module dual_txq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_sof,
  input logic       tx_eof,
  input logic       tx_chan,
  input logic       soft_clr,
  input logic       rx_done,
  input logic [2:0] istat
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !soft_clr |=> tx_valid && $stable(tx_data) &&
      $stable(tx_chan) && $stable(tx_sof) && $stable(tx_eof));

  a_r8_next_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof |=> !tx_valid || tx_sof);

  a_r8_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !tx_eof && !soft_clr |=> tx_valid && !tx_sof && $stable(tx_chan));

  a_r7_done_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof && !tx_chan && !soft_clr |=> istat[0]);

  a_r7_done_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof && tx_chan && !soft_clr |=> istat[1]);

  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !tx_valid && (istat == 3'b000));

  a_r13_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !soft_clr |=> istat[2]);
endmodule

bind dual_txq dual_txq_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_chan(tx_chan),
  .soft_clr(soft_clr), .rx_done(rx_done), .istat(istat)
);

// File: tb/sim_dual_txq.sv
module sim_dual_txq;
  localparam int CLK_PERIOD = 10;
  localparam int FB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rx_done = 1'b0;
  logic        rx_flush;
  logic        tx_valid, tx_ready, tx_sof, tx_eof, tx_chan, irq;
  logic [7:0]  tx_data;

  dual_txq #(.FIFO_BYTES(FB)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_done(rx_done), .rx_flush(rx_flush),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_chan(tx_chan), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // ready pattern: pat 0 -> always ready, else ready unless cycle divisible by pat
  int  pat = 0;
  int  cyc = 0;
  logic pat_bit = 1'b1;
  logic hold_ready = 1'b0;
  assign tx_ready = hold_ready ? 1'b0 : pat_bit;
  always @(negedge clk) begin
    cyc++;
    pat_bit = (pat == 0) || ((cyc % pat) != 0);
  end

  // stream capture
  logic [7:0] cap_d [4096];
  logic       cap_s [4096];
  logic       cap_e [4096];
  logic       cap_c [4096];
  int cap_n = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      cap_d[cap_n & 4095] = tx_data;
      cap_s[cap_n & 4095] = tx_sof;
      cap_e[cap_n & 4095] = tx_eof;
      cap_c[cap_n & 4095] = tx_chan;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_pulse();
    @(negedge clk); rx_done = 1'b1;
    @(negedge clk); rx_done = 1'b0;
  endtask

  function automatic logic [31:0] wpat(input int ch, input int f, input int k);
    return {8'(8'h50 + k), 8'(f), 8'(8'h10 + ch), 8'(k * 17 + f)};
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic wait_stat(input int bitn);
    logic [31:0] v;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      rd(4'd8, v);
      if (v[bitn]) break;
    end
    idle(1);
  endtask

  // R2 R6 R7 R8: one frame with the given shape
  task automatic run_frame(input int ch, input int nw, input int len, input int f);
    logic [31:0] v;
    int base, eff, ok;
    wr(4'd1, 32'(ch));
    for (int k = 0; k < nw; k++) wr(4'd2, wpat(ch, f, k));
    wr(4'(3 + ch), 32'(len));
    pat = (f % 3 == 0) ? 0 : (f % 3) + 1;
    base = cap_n;
    wr(4'(5 + ch), 32'd1);
    eff = imin(imin(len, FB), nw * 4);
    if (eff > 0) begin
      wait_stat(ch);
      chk(cap_n - base == eff, "R6 frame byte count", cap_n - base, eff);
      ok = 1;
      for (int j = 0; j < eff; j++) begin
        logic [31:0] w;
        int ix;
        ix = (base + j) & 4095;
        w = wpat(ch, f, j / 4);
        if (cap_d[ix] != w[8*(j%4) +: 8]) ok = 0;
        if (cap_s[ix] != (j == 0)) ok = 0;
        if (cap_e[ix] != (j == eff - 1)) ok = 0;
        if (cap_c[ix] != 1'(ch)) ok = 0;
      end
      chk(ok == 1, "R2 R8 frame bytes and markers", f, ch);
      rd(4'(3 + ch), v);
      chk(v == 0, "R7 length cleared", v, 0);
      rd(4'd8, v);
      chk(v == (32'd1 << ch), "R7 status bit", v, 32'd1 << ch);
      wr(4'd8, 32'd7);
      rd(4'd8, v);
      chk(v == 0, "R9 w1c clears", v, 0);
    end else begin
      idle(8);
      chk(cap_n == base, "R6 zero length sends nothing", cap_n - base, 0);
      rd(4'd8, v);
      chk(v == 0, "R6 zero length no status", v, 0);
      wr(4'd0, 32'h5);
    end
    pat = 0;
  endtask

  task automatic set_all();
    wr(4'd1, 0); wr(4'd2, 32'h11223344); wr(4'd3, 4); wr(4'd5, 1); idle(8);
    wr(4'd1, 1); wr(4'd2, 32'h55667788); wr(4'd4, 4); wr(4'd6, 1); idle(8);
    rx_pulse();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // reset state
    rd(4'd0, v); chk(v == 0, "R11 reset ctrl", v, 0);
    rd(4'd1, v); chk(v == 0, "R1 reset chsel", v, 0);
    rd(4'd8, v); chk(v == 0, "R9 reset status", v, 0);
    chk(irq == 0 && tx_valid == 0, "R9 reset irq/valid", {irq, tx_valid}, 0);

    // R1 select sweep
    for (int s = 0; s < 8; s++) begin
      int e;
      e = (s < 2) ? s : 0;
      wr(4'd1, 32'(s)); rd(4'd1, v);
      chk(v == 32'(e), "R1 select value", v, e);
    end
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v);
    chk(v == 0, "R1 large select", v, 0);

    // R4 clamp sweep
    for (int ch = 0; ch < 2; ch++) begin
      for (int l = 0; l < 22; l++) begin
        wr(4'(3 + ch), 32'(l)); rd(4'(3 + ch), v);
        chk(v == 32'(imin(l, FB)), "R4 length clamp", v, imin(l, FB));
      end
      wr(4'(3 + ch), 32'h8000_0000); rd(4'(3 + ch), v);
      chk(v == FB, "R4 huge length", v, FB);
      wr(4'(3 + ch), 0);
    end

    // R5 start without enable
    wr(4'd1, 0); wr(4'd2, 32'hA1B2C3D4); wr(4'd3, 4);
    base = cap_n;
    wr(4'd5, 1); idle(8);
    chk(cap_n == base, "R5 start ignored when disabled", cap_n - base, 0);
    rd(4'd8, v); chk(v == 0, "R5 no status when disabled", v, 0);
    wr(4'd0, 32'h1);
    rd(4'd0, v); chk(v == 1, "R5 enable stored", v, 1);
    wr(4'd5, 2); idle(8);
    chk(cap_n == base, "R5 start needs bit 0", cap_n - base, 0);
    wr(4'd5, 1); wait_stat(0);
    chk(cap_n - base == 4 && cap_d[base & 4095] == 8'hD4 && cap_d[(base + 3) & 4095] == 8'hA1,
        "R5 queued data kept and sent", cap_d[base & 4095], 8'hD4);
    wr(4'd8, 7);

    // R2 R6 R7 R8 sweep
    begin
      int f;
      f = 0;
      for (int ch = 0; ch < 2; ch++)
        for (int nw = 1; nw <= 4; nw++)
          for (int len = 0; len <= FB + 1; len++) begin
            run_frame(ch, nw, len, f);
            f++;
          end
    end

    // R3 overflow drop, R4 clamp at start
    wr(4'd1, 1);
    for (int k = 0; k < 5; k++) wr(4'd2, wpat(1, 200, k));
    wr(4'd4, 20); rd(4'd4, v); chk(v == FB, "R4 clamp before start", v, FB);
    base = cap_n;
    wr(4'd6, 1); wait_stat(1);
    chk(cap_n - base == FB, "R3 count after overflow", cap_n - base, FB);
    chk(cap_d[(base + FB - 1) & 4095] == wpat(1, 200, 3)[31:24], "R3 fifth word dropped",
        cap_d[(base + FB - 1) & 4095], wpat(1, 200, 3)[31:24]);
    wr(4'd8, 7);

    // R9 irq mask sweep and W1C sweep, R13 rx event
    set_all();
    rd(4'd8, v); chk(v == 7, "R13 rx sets bit 2", v, 7);
    for (int m = 0; m < 8; m++) begin
      wr(4'd7, 32'(m));
      rd(4'd7, v); chk(v == 32'(m), "R9 mask readback", v, m);
      chk(irq == (m != 0), "R9 irq vs mask", irq, m != 0);
    end
    for (int c = 0; c < 8; c++) begin
      set_all();
      wr(4'd7, 5);
      wr(4'd8, 32'(c));
      rd(4'd8, v);
      chk(v == 32'(7 & ~c), "R9 w1c pattern", v, 7 & ~c);
      chk(irq == (((7 & ~c) & 5) != 0), "R9 irq after clear", irq, ((7 & ~c) & 5) != 0);
      wr(4'd8, 7);
    end
    wr(4'd7, 0);

    // R10 set versus clear in one cycle
    hold_ready = 1'b1;
    wr(4'd1, 0); wr(4'd2, 32'h0000_00EE); wr(4'd3, 1);
    base = cap_n;
    wr(4'd5, 1); idle(4);
    chk(tx_valid && tx_sof && tx_eof && tx_data == 8'hEE, "R8 stalled single byte",
        {tx_valid, tx_sof, tx_eof}, 3'b111);
    @(negedge clk);
    hold_ready = 1'b0; wr_en = 1'b1; wr_addr = 4'd8; wr_data = 32'd5; rx_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rx_done = 1'b0;
    rd(4'd8, v);
    chk(v == 5, "R10 set wins over clear", v, 5);
    wr(4'd8, 7);

    // R12 busy restart ignored, other channel queued
    wr(4'd1, 1); wr(4'd2, 32'h9988_7766);
    wr(4'd1, 0);
    for (int k = 0; k < 4; k++) wr(4'd2, wpat(0, 300, k));
    wr(4'd3, 16); wr(4'd4, 4);
    base = cap_n;
    wr(4'd5, 1); wr(4'd6, 1); wr(4'd5, 1);
    idle(40);
    chk(cap_n - base == 20, "R12 total bytes", cap_n - base, 20);
    begin
      int ok;
      ok = 1;
      for (int j = 0; j < 20; j++) if (cap_c[(base + j) & 4095] != (j >= 16)) ok = 0;
      chk(ok == 1, "R12 channel order", ok, 1);
    end
    chk(cap_d[(base + 16) & 4095] == 8'h66, "R12 held frame data", cap_d[(base + 16) & 4095], 8'h66);
    rd(4'd8, v); chk(v == 3, "R12 both completed", v, 3);

    // R11 control reset
    wr(4'd1, 1); wr(4'd7, 7); wr(4'd2, 32'hDEAD_BEEF); wr(4'd4, 8);
    rx_pulse();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h5;
    #1; chk(rx_flush == 1, "R11 flush pulse", rx_flush, 1);
    @(negedge clk);
    wr_en = 1'b0;
    #1; chk(rx_flush == 0, "R11 flush one cycle", rx_flush, 0);
    rd(4'd0, v); chk(v == 1, "R11 reset bit not stored", v, 1);
    rd(4'd1, v); chk(v == 0, "R11 select cleared", v, 0);
    rd(4'd7, v); chk(v == 0, "R11 mask cleared", v, 0);
    rd(4'd8, v); chk(v == 0, "R11 status cleared", v, 0);
    rd(4'd4, v); chk(v == 0, "R11 length cleared", v, 0);
    wr(4'd1, 1); wr(4'd2, 32'h0403_0201); wr(4'd4, 8);
    base = cap_n;
    wr(4'd6, 1); wait_stat(1);
    chk(cap_n - base == 4 && cap_d[base & 4095] == 8'h01, "R11 old data discarded",
        cap_n - base, 4);
    wr(4'd8, 7);

    // R11 reset in flight
    pat = 3;
    wr(4'd1, 0);
    for (int k = 0; k < 4; k++) wr(4'd2, wpat(0, 400, k));
    wr(4'd3, 16);
    wr(4'd5, 1); idle(3);
    wr(4'd0, 32'h5);
    base = cap_n;
    idle(20);
    chk(cap_n == base && tx_valid == 0, "R11 frame in flight dropped", cap_n - base, 0);
    rd(4'd8, v); chk(v == 0, "R11 no completion after reset", v, 0);
    pat = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule